// File: doc/BRIEF.md
# Two-Channel DMA Enable and Status Register

This block is the single control and status byte of a two-channel DMA controller. Software uses it to start and stop each channel, to choose which channels raise an interrupt when they finish, and to read back which channels are still running. The transfer engines send a one-cycle terminal-count pulse when their byte counter runs out. The register then drops that channel's enable, which raises the interrupt request if that channel's interrupt is enabled.

A master gate sits above both channel enables. A non-maskable interrupt shuts this gate so that no DMA runs during its service routine. Software cannot write the gate directly. It opens again as a side effect of any accepted write of 1 to a channel enable, including a rewrite of a 1 that is already set. Each channel enable has a companion guard bit in the same write. The enable changes only when its guard is written as 0, so software can update one field without disturbing the other channel.

The engines use the `ch_active` outputs as their run qualifiers. The CPU uses `irq` together with the per-channel `ch_irq` lines.

Top module: `dmastat_reg`

## Requirements
- R1: `ch_active[c]` is 1 exactly when channel c's enable (read bit 6 for channel 0, bit 7 for channel 1) and the master gate (read bit 0) are both 1.
- R2: A terminal-count pulse on `tc_pulse[c]` clears channel c's enable on the next clock edge, unless the same cycle carries an accepted software write to that enable.
- R3: `ch_irq[c]` is 1 while channel c's enable is 0 and its interrupt enable (bit 2 for channel 0, bit 3 for channel 1) is 1. `irq` is the OR of both `ch_irq` lines.
- R4: A write updates channel c's enable only when its guard bit (write bit 4 for channel 0, bit 5 for channel 1) is 0. With the guard at 1, the enable keeps its value.
- R5: Readback layout: bit7 = channel-1 enable, bit6 = channel-0 enable, bits 5 and 4 always read 1, bit3 = channel-1 interrupt enable, bit2 = channel-0 interrupt enable, bit1 always reads 1, bit0 = master gate.
- R6: An accepted write of 1 to either channel enable sets the master gate to 1, even when that enable was already 1.
- R7: An accepted write of 0 stops that channel. A later accepted write of 1 restarts it.
- R8: Write bit 0 has no effect on the master gate. A pulse on `nmi_pulse` clears the master gate on the next edge.
- R9: While `rst_n` is low the register reads 0x32 (all enables and the gate 0), with no active channel and no interrupt.
- R10: When a terminal-count pulse coincides with an accepted write of 1 to the same enable, the enable ends at 1. When an NMI coincides with a write that would set the gate, the gate ends at 0.
- R11: Every write loads both interrupt-enable bits from write bits 2 and 3, regardless of the guard bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Current register contents |
| tc_pulse | input | 2 | Per-channel terminal-count pulse from the transfer engines |
| nmi_pulse | input | 1 | Non-maskable interrupt event |
| ch_active | output | 2 | Per-channel run qualifier for the transfer engines |
| ch_irq | output | 2 | Per-channel termination interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `wr_stb`, `tc_pulse` and `nmi_pulse` are sampled at the rising edge and act as single-cycle events, and that all inputs are known whenever reset is released. The stimulus keeps to this: every input changes only on the falling edge, and every event is held for exactly one cycle before it is dropped. Coinciding events are applied deliberately, so the priority rules (write over terminal count, NMI over gate set) see the same timing as an isolated event.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;

  // register geometry: channel enables on top, then guards, then
  // interrupt enables, spare bit, master gate at bit 0
  localparam int unsigned CH_N      = 2;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned EN_LSB    = REG_W - CH_N;
  localparam int unsigned GD_LSB    = EN_LSB - CH_N;
  localparam int unsigned IE_LSB    = GD_LSB - CH_N;
  localparam int unsigned SPARE_BIT = 1;
  localparam int unsigned GATE_BIT  = 0;

  localparam logic [REG_W-1:0] RESET_VIEW =
    ({{CH_N{1'b1}}, {GD_LSB{1'b0}}} & {REG_W{1'b1}}) | (REG_W'(1) << SPARE_BIT);

  // software write beats a terminal count in the same cycle
  function automatic logic next_chan_en(input logic cur, input logic wr_hit,
                                        input logic wr_val, input logic tc);
    logic nxt;
    nxt = cur;
    if (tc)     nxt = 1'b0;
    if (wr_hit) nxt = wr_val;
    return nxt;
  endfunction

  // NMI beats any set request in the same cycle
  function automatic logic next_gate(input logic cur, input logic set_req,
                                     input logic nmi);
    logic nxt;
    nxt = cur;
    if (set_req) nxt = 1'b1;
    if (nmi)     nxt = 1'b0;
    return nxt;
  endfunction

  function automatic logic term_req(input logic en, input logic ie);
    return ie & ~en;
  endfunction

endpackage

// File: rtl/dmastat_chan.sv
module dmastat_chan
  import dmastat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_en_val,
  input  logic wr_guard,
  input  logic wr_ie_val,
  input  logic tc,
  output logic en_q,
  output logic ie_q,
  output logic set_gate,
  output logic term_irq
);

  logic en_wr_hit;
  logic en_d;

  // enable field accepted only with its guard written low
  assign en_wr_hit = wr_stb & ~wr_guard;
  assign en_d      = next_chan_en(en_q, en_wr_hit, wr_en_val, tc);
  assign set_gate  = en_wr_hit & wr_en_val;
  assign term_irq  = term_req(en_q, ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (wr_stb) ie_q <= wr_ie_val;
    end
  end

endmodule

// File: rtl/dmastat_gate.sv
module dmastat_gate
  import dmastat_pkg::*;
#(
  parameter int unsigned N = CH_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic         nmi,
  output logic         gate_q
);

  logic any_set;
  assign any_set = |set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= next_gate(gate_q, any_set, nmi);
  end

endmodule

// File: rtl/dmastat_view.sv
module dmastat_view
  import dmastat_pkg::*;
(
  input  logic [CH_N-1:0]  en,
  input  logic [CH_N-1:0]  ie,
  input  logic             gate,
  output logic [REG_W-1:0] view
);

  always_comb begin
    view                    = '0;
    view[EN_LSB +: CH_N]    = en;
    view[GD_LSB +: CH_N]    = '1;
    view[IE_LSB +: CH_N]    = ie;
    view[SPARE_BIT]         = 1'b1;
    view[GATE_BIT]          = gate;
  end

endmodule

// File: rtl/dmastat_reg.sv
module dmastat_reg
  import dmastat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [CH_N-1:0]  tc_pulse,
  input  logic             nmi_pulse,
  output logic [CH_N-1:0]  ch_active,
  output logic [CH_N-1:0]  ch_irq,
  output logic             irq
);

  logic [CH_N-1:0] en_bits;
  logic [CH_N-1:0] ie_bits;
  logic [CH_N-1:0] gate_set;
  logic            gate;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    dmastat_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_en_val (wr_data[EN_LSB + c]),
      .wr_guard  (wr_data[GD_LSB + c]),
      .wr_ie_val (wr_data[IE_LSB + c]),
      .tc        (tc_pulse[c]),
      .en_q      (en_bits[c]),
      .ie_q      (ie_bits[c]),
      .set_gate  (gate_set[c]),
      .term_irq  (ch_irq[c])
    );
  end

  dmastat_gate #(.N(CH_N)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (gate_set),
    .nmi     (nmi_pulse),
    .gate_q  (gate)
  );

  dmastat_view u_view (
    .en   (en_bits),
    .ie   (ie_bits),
    .gate (gate),
    .view (rd_data)
  );

  assign ch_active = en_bits & {CH_N{gate}};
  assign irq       = |ch_irq;

endmodule

// File: rtl/dmastat_chk.sv
module dmastat_chk
  import dmastat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [CH_N-1:0]  tc_pulse,
  input logic             nmi_pulse,
  input logic [CH_N-1:0]  ch_active,
  input logic [CH_N-1:0]  ch_irq,
  input logic             irq
);

  logic any_gate_set;
  assign any_gate_set = wr_stb &&
    (((~wr_data[GD_LSB +: CH_N]) & wr_data[EN_LSB +: CH_N]) != '0);

  for (genvar c = 0; c < CH_N; c++) begin : g_c
    // R1
    a_r1_active_qual: assert property (@(posedge clk) disable iff (!rst_n)
      ch_active[c] == (rd_data[EN_LSB + c] && rd_data[GATE_BIT]));
    // R2
    a_r2_tc_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse[c] && !(wr_stb && !wr_data[GD_LSB + c])) |=> !rd_data[EN_LSB + c]);
    // R3
    a_r3_chan_req: assert property (@(posedge clk) disable iff (!rst_n)
      ch_irq[c] == (!rd_data[EN_LSB + c] && rd_data[IE_LSB + c]));
    // R4
    a_r4_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_data[GD_LSB + c] && !tc_pulse[c]) |=> $stable(rd_data[EN_LSB + c]));
    // R10
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse[c] && wr_stb && !wr_data[GD_LSB + c] && wr_data[EN_LSB + c])
        |=> rd_data[EN_LSB + c]);
  end

  // R3
  a_r3_combined: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ch_irq != '0));
  // R5
  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[GD_LSB +: CH_N] == '1) && rd_data[SPARE_BIT]);
  // R6
  a_r6_gate_set: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gate_set && !nmi_pulse) |=> rd_data[GATE_BIT]);
  // R8
  a_r8_nmi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !rd_data[GATE_BIT]);
  // R8
  a_r8_no_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_gate_set && !nmi_pulse) |=> $stable(rd_data[GATE_BIT]));
  // R11
  a_r11_ie_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> rd_data[IE_LSB +: CH_N] == $past(wr_data[IE_LSB +: CH_N]));

endmodule

bind dmastat_reg dmastat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .tc_pulse  (tc_pulse),
  .nmi_pulse (nmi_pulse),
  .ch_active (ch_active),
  .ch_irq    (ch_irq),
  .irq       (irq)
);

// File: tb/dmastat_reg_bench.sv
module dmastat_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] tc_pulse = 2'b00;
  logic       nmi_pulse = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] ch_active;
  logic [1:0] ch_irq;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmastat_reg u_dmastat_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .tc_pulse  (tc_pulse),
    .nmi_pulse (nmi_pulse),
    .ch_active (ch_active),
    .ch_irq    (ch_irq),
    .irq       (irq)
  );

  // {wr, data, tc, nmi, exp_rd, exp_active, exp_chirq, exp_irq}
  localparam int NV = 12;
  localparam logic [24:0] VEC [0:NV-1] = '{
    {1'b1, 8'h45, 2'b00, 1'b0, 8'h77, 2'b01, 2'b00, 1'b0}, // R6 start ch0, R8 bit0 ignored
    {1'b0, 8'h00, 2'b01, 1'b0, 8'h37, 2'b00, 2'b01, 1'b1}, // R2 tc ch0, R3 request
    {1'b1, 8'hCC, 2'b00, 1'b0, 8'hFF, 2'b11, 2'b00, 1'b0}, // R7 restart, R11 ie load
    {1'b1, 8'h3C, 2'b00, 1'b0, 8'hFF, 2'b11, 2'b00, 1'b0}, // R4 guards hold
    {1'b0, 8'h00, 2'b00, 1'b1, 8'hFE, 2'b00, 2'b00, 1'b0}, // R8 nmi clears gate
    {1'b1, 8'h3D, 2'b00, 1'b0, 8'hFE, 2'b00, 2'b00, 1'b0}, // R8 direct write ignored
    {1'b1, 8'hDC, 2'b00, 1'b0, 8'hFF, 2'b11, 2'b00, 1'b0}, // R6 rewrite 1 restarts
    {1'b1, 8'h9C, 2'b10, 1'b0, 8'hFF, 2'b11, 2'b00, 1'b0}, // R10 write beats tc
    {1'b1, 8'h2C, 2'b00, 1'b0, 8'hBF, 2'b10, 2'b01, 1'b1}, // R7 stop ch0
    {1'b1, 8'h68, 2'b00, 1'b0, 8'hFB, 2'b11, 2'b00, 1'b0}, // R11 ie0 cleared
    {1'b1, 8'h40, 2'b00, 1'b1, 8'h72, 2'b00, 2'b00, 1'b0}, // R10 nmi beats set
    {1'b0, 8'h00, 2'b11, 1'b0, 8'h32, 2'b00, 2'b00, 1'b0}  // R2 tc both
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset readback", rd_data, 8'h32);
    chk("R9 reset active", {6'd0, ch_active}, 8'h00);
    chk("R9 reset irq", {5'd0, ch_irq, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_stb    = VEC[i][24];
      wr_data   = VEC[i][23:16];
      tc_pulse  = VEC[i][15:14];
      nmi_pulse = VEC[i][13];
      @(posedge clk);
      #2;
      wr_stb    = 1'b0;
      tc_pulse  = 2'b00;
      nmi_pulse = 1'b0;
      chk($sformatf("R5 readback vec %0d", i), rd_data, VEC[i][12:5]);
      chk($sformatf("R1 active vec %0d", i), {6'd0, ch_active}, {6'd0, VEC[i][4:3]});
      chk($sformatf("R3 irq vec %0d", i), {5'd0, ch_irq, irq}, {5'd0, VEC[i][2:0]});
    end

    // R2: tc and an accepted write of 0 together leave the enable at 0
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h0C; tc_pulse = 2'b01;
    @(posedge clk); #2;
    wr_stb = 1'b0; tc_pulse = 2'b00;
    chk("R2 tc with write 0", rd_data, 8'h3E);
    chk("R3 both requests", {5'd0, ch_irq, irq}, 8'h07);

    // R9: reset in mid-run
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'hCC;
    @(posedge clk); #2;
    wr_stb = 1'b0;
    chk("R6 running before reset", rd_data, 8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 mid-run reset", rd_data, 8'h32);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule